// File: doc/BRIEF.md
# Interleaved Reed-Solomon frame encoder

This block protects one 88-bit payload per frame cycle by wrapping it into a 120-bit frame. It carries two Reed-Solomon codes, each RS(15,11) over GF(16) with 4-bit symbols. The payload is dealt out symbol by symbol, alternately, into the two codewords. Each codeword gains four parity symbols. In the output frame the symbols of the two codewords alternate again. An aligned burst of up to 16 corrupted bits therefore touches at most two symbols of each codeword, and each code corrects two symbol errors. The frame efficiency is 88/120, about 73%. At a 40 MHz frame rate the line carries 4.8 Gb/s.

The whole parity computation is combinational and fits in one frame cycle. It is followed by a single output register. Both edges are valid/ready streams. A beat is taken when `in_valid` and `in_ready` are high at the same rising edge. The result shows up on the next edge. Back-pressure from `out_ready` stalls the register in place, and `in_ready` drops while a frame is held and not yet consumed. The sender may withdraw `in_valid` at any time; only accepted beats count. Scrambling, header insertion, serialization and decoding belong to neighbouring blocks.

Top module: `rs_frame_encoder`

## Requirements
- R1: Arithmetic is in GF(16) built on x^4 + x + 1 with alpha = 2. The generator is g(x) = x^4 + 13x^3 + 12x^2 + 8x + 7, whose roots are alpha^1 through alpha^4. Every codeword in a valid output frame therefore evaluates to zero at alpha^1, alpha^2, alpha^3 and alpha^4.
- R2: Payload symbol k occupies `in_payload[4k+3:4k]`, for k = 0..21. Even k goes to codeword A as data symbol k/2, and odd k goes to codeword B as data symbol (k-1)/2. Data symbol 0 is the coefficient of x^14 and data symbol 10 is the coefficient of x^4.
- R3: The code is systematic. `out_frame[87:0]` equals the accepted payload bit for bit.
- R4: Parity symbol m (m = 0..3, where parity 0 is the coefficient of x^3) is the remainder of data(x)·x^4 divided by g(x). Frame symbol 22+2m, at bits [4s+3:4s], holds parity m of codeword A, and frame symbol 23+2m holds parity m of codeword B. An all-zero payload gives an all-zero frame.
- R5: A beat accepted at one rising edge is presented, with `out_valid` high, right after that edge. The latency is exactly one clock.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_frame` keep their values.
- R7: `in_ready` is high whenever the output register is empty or `out_ready` is high. With `out_ready` held high, one beat is accepted every clock.
- R8: When no beat is accepted, `out_frame` keeps its value whatever `in_payload` does. `out_valid` falls after a consumed frame has no successor.
- R9: While `rst_n` is low, `out_valid` is low, `out_frame` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload beat offered |
| in_ready | output | 1 | Encoder can take a beat this edge |
| in_payload | input | 88 | Payload, 22 symbols of 4 bits |
| out_valid | output | 1 | Protected frame present |
| out_ready | input | 1 | Downstream takes the frame this edge |
| out_frame | output | 120 | Protected frame, 30 interleaved symbols |

## Verification
The assertions take for granted that `in_valid`, `out_ready` and `in_payload` carry known values at every sampling edge after reset. The systematic-copy and root checks compare X-free data, and the stall properties depend on a defined `out_ready`. The stimulus drives every input to a defined value on each falling edge, including idle cycles, where the payload carries random junk rather than X. It does not rely on `in_valid` being held under a stall, because the encoder latches only on acceptance.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 4;
  localparam logic [SYM_W:0] FIELD_POLY = 5'b10011;
  localparam logic [SYM_W-1:0] ALPHA = 4'd2;
  localparam int MAX_PAR = 8;
  localparam int FIELD_LEN = (1 << SYM_W) - 1;

  // multiply two field elements by shift-and-reduce
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
      else             sh = sh << 1;
    end
    return acc;
  endfunction

  function automatic logic [SYM_W-1:0] alpha_pow(input int e);
    logic [SYM_W-1:0] r;
    r = 1;
    for (int i = 0; i < e; i++) r = gf_mul(r, ALPHA);
    return r;
  endfunction

  // low coefficients of the monic generator prod (x + alpha^i), i = 1..npar
  function automatic logic [MAX_PAR*SYM_W-1:0] gen_coefs(input int npar);
    logic [SYM_W-1:0] g [MAX_PAR+1];
    logic [SYM_W-1:0] root;
    logic [MAX_PAR*SYM_W-1:0] packed_g;
    for (int j = 0; j <= MAX_PAR; j++) g[j] = '0;
    g[0] = 1;
    for (int i = 1; i <= MAX_PAR; i++) begin
      if (i <= npar) begin
        root = alpha_pow(i);
        for (int j = MAX_PAR; j >= 1; j--) begin
          if (j <= i) g[j] = g[j-1] ^ gf_mul(g[j], root);
        end
        g[0] = gf_mul(g[0], root);
      end
    end
    packed_g = '0;
    for (int j = 0; j < MAX_PAR; j++) packed_g[j*SYM_W +: SYM_W] = g[j];
    return packed_g;
  endfunction
endpackage

// File: rtl/rs_frame_split.sv
module rs_frame_split #(
  parameter int NCODES = 2,
  parameter int K_SYMS = 11,
  parameter int SYM_W  = 4,
  localparam int DATA_W = NCODES * K_SYMS * SYM_W
) (
  input  logic [DATA_W-1:0] payload_i,
  output logic [DATA_W-1:0] cw_data_o
);
  // codeword c, data symbol j  <-  payload symbol j*NCODES + c
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    for (genvar j = 0; j < K_SYMS; j++) begin : g_sym
      assign cw_data_o[(c*K_SYMS + j)*SYM_W +: SYM_W] =
        payload_i[(j*NCODES + c)*SYM_W +: SYM_W];
    end
  end
endmodule

// File: rtl/rs_cw_encoder.sv
module rs_cw_encoder
  import rs_enc_pkg::*;
#(
  parameter int K_SYMS = 11,
  parameter int N_PAR  = 4
) (
  input  logic [K_SYMS*SYM_W-1:0] data_i,
  output logic [N_PAR*SYM_W-1:0]  par_o
);
  localparam logic [MAX_PAR*SYM_W-1:0] GEN = gen_coefs(N_PAR);

  if (N_PAR > MAX_PAR || K_SYMS + N_PAR > FIELD_LEN) begin : g_bad_size
    $error("rs_cw_encoder: code size does not fit the field");
  end

  // polynomial division unrolled over the data symbols, highest degree first
  always_comb begin
    logic [SYM_W-1:0] rem [N_PAR];
    logic [SYM_W-1:0] fb;
    for (int i = 0; i < N_PAR; i++) rem[i] = '0;
    for (int j = 0; j < K_SYMS; j++) begin
      fb = data_i[j*SYM_W +: SYM_W] ^ rem[N_PAR-1];
      for (int i = N_PAR-1; i >= 1; i--)
        rem[i] = rem[i-1] ^ gf_mul(fb, GEN[i*SYM_W +: SYM_W]);
      rem[0] = gf_mul(fb, GEN[0 +: SYM_W]);
    end
    for (int m = 0; m < N_PAR; m++) par_o[m*SYM_W +: SYM_W] = rem[N_PAR-1-m];
  end
endmodule

// File: rtl/rs_frame_merge.sv
module rs_frame_merge #(
  parameter int NCODES = 2,
  parameter int K_SYMS = 11,
  parameter int N_PAR  = 4,
  parameter int SYM_W  = 4,
  localparam int N_SYMS  = K_SYMS + N_PAR,
  localparam int DATA_W  = NCODES * K_SYMS * SYM_W,
  localparam int PAR_W   = NCODES * N_PAR * SYM_W,
  localparam int FRAME_W = NCODES * N_SYMS * SYM_W
) (
  input  logic [DATA_W-1:0]  cw_data_i,
  input  logic [PAR_W-1:0]   cw_par_i,
  output logic [FRAME_W-1:0] frame_o
);
  // frame symbol m*NCODES + c  <-  codeword c, symbol m
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    for (genvar m = 0; m < N_SYMS; m++) begin : g_sym
      if (m < K_SYMS) begin : g_data
        assign frame_o[(m*NCODES + c)*SYM_W +: SYM_W] =
          cw_data_i[(c*K_SYMS + m)*SYM_W +: SYM_W];
      end else begin : g_par
        assign frame_o[(m*NCODES + c)*SYM_W +: SYM_W] =
          cw_par_i[(c*N_PAR + m - K_SYMS)*SYM_W +: SYM_W];
      end
    end
  end
endmodule

// File: rtl/rs_frame_encoder.sv
module rs_frame_encoder
  import rs_enc_pkg::*;
#(
  parameter int NCODES = 2,
  parameter int K_SYMS = 11,
  parameter int N_PAR  = 4,
  localparam int N_SYMS    = K_SYMS + N_PAR,
  localparam int CW_DATA_W = K_SYMS * SYM_W,
  localparam int CW_PAR_W  = N_PAR * SYM_W,
  localparam int DATA_W    = NCODES * CW_DATA_W,
  localparam int FRAME_W   = NCODES * N_SYMS * SYM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_payload,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FRAME_W-1:0] out_frame
);
  logic [DATA_W-1:0]          cw_data;
  logic [NCODES*CW_PAR_W-1:0] cw_par;
  logic [FRAME_W-1:0]         frame_d;
  logic                       take;

  rs_frame_split #(.NCODES(NCODES), .K_SYMS(K_SYMS), .SYM_W(SYM_W)) i_split (
    .payload_i (in_payload),
    .cw_data_o (cw_data)
  );

  for (genvar c = 0; c < NCODES; c++) begin : g_enc
    rs_cw_encoder #(.K_SYMS(K_SYMS), .N_PAR(N_PAR)) i_enc (
      .data_i (cw_data[c*CW_DATA_W +: CW_DATA_W]),
      .par_o  (cw_par[c*CW_PAR_W +: CW_PAR_W])
    );
  end

  rs_frame_merge #(.NCODES(NCODES), .K_SYMS(K_SYMS), .N_PAR(N_PAR), .SYM_W(SYM_W)) i_merge (
    .cw_data_i (cw_data),
    .cw_par_i  (cw_par),
    .frame_o   (frame_d)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_frame <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_frame <= frame_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_frame_encoder_chk.sv
module rs_frame_encoder_chk
  import rs_enc_pkg::*;
#(
  parameter int NCODES = 2,
  parameter int K_SYMS = 11,
  parameter int N_PAR  = 4,
  localparam int N_SYMS  = K_SYMS + N_PAR,
  localparam int DATA_W  = NCODES * K_SYMS * SYM_W,
  localparam int FRAME_W = NCODES * N_SYMS * SYM_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DATA_W-1:0]  in_payload,
  input logic               out_valid,
  input logic               out_ready,
  input logic [FRAME_W-1:0] out_frame
);
  logic roots_ok;

  // evaluate every codeword at alpha^1..alpha^N_PAR (Horner, highest degree first)
  always_comb begin
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] ap;
    roots_ok = 1'b1;
    for (int c = 0; c < NCODES; c++) begin
      for (int i = 1; i <= N_PAR; i++) begin
        ap  = alpha_pow(i);
        acc = '0;
        for (int m = 0; m < N_SYMS; m++)
          acc = gf_mul(acc, ap) ^ out_frame[(m*NCODES + c)*SYM_W +: SYM_W];
        if (acc != '0) roots_ok = 1'b0;
      end
    end
  end

  // R1
  a_r1_codeword_roots: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> roots_ok);
  // R3
  a_r3_systematic_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_frame[DATA_W-1:0] == $past(in_payload)));
  // R5
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R6
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_frame)));
  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R7
  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R8
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_frame));
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind rs_frame_encoder rs_frame_encoder_chk #(
  .NCODES(NCODES), .K_SYMS(K_SYMS), .N_PAR(N_PAR)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_payload (in_payload),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_frame  (out_frame)
);

// File: tb/test_rs_frame_encoder.sv
`timescale 1ns/1ps
module test_rs_frame_encoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [87:0]  in_payload = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [119:0] out_frame;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string phase = "R9 reset";

  // reference state
  logic         exp_valid = 1'b0;
  logic [119:0] exp_frame = '0;

  always #5 clk = ~clk;

  rs_frame_encoder i_rs_frame_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_frame(out_frame)
  );

  function automatic int bmul(input int a, input int b);
    int r = 0;
    for (int i = 0; i < 4; i++) begin
      if ((b >> i) & 1) r ^= a;
      a = a << 1;
      if (a & 16) a ^= 19;
    end
    return r;
  endfunction

  // long division by g = x^4 + 13x^3 + 12x^2 + 8x + 7
  function automatic logic [119:0] ref_encode(input logic [87:0] p);
    int gfull [5] = '{7, 8, 12, 13, 1};
    int msg [15];
    logic [119:0] f;
    f = '0;
    f[87:0] = p;
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 15; d++) msg[d] = 0;
      for (int j = 0; j < 11; j++) msg[14-j] = int'(p[(2*j + c)*4 +: 4]);
      for (int d = 14; d >= 4; d--) begin
        int co = msg[d];
        for (int t = 0; t < 5; t++) msg[d-4+t] ^= bmul(co, gfull[t]);
      end
      for (int m = 0; m < 4; m++) f[(22 + 2*m + c)*4 +: 4] = 4'(msg[3-m]);
    end
    return f;
  endfunction

  function automatic bit roots_zero(input logic [119:0] f);
    bit ok = 1'b1;
    for (int c = 0; c < 2; c++) begin
      for (int i = 1; i <= 4; i++) begin
        int ap = 1;
        int acc = 0;
        for (int e = 0; e < i; e++) ap = bmul(ap, 2);
        for (int m = 0; m < 15; m++) acc = bmul(acc, ap) ^ int'(f[(2*m + c)*4 +: 4]);
        if (acc != 0) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 1'b0;
      exp_frame = '0;
    end else if (in_valid && (!exp_valid || out_ready)) begin
      exp_valid = 1'b1;
      exp_frame = ref_encode(in_payload);
    end else if (out_ready) begin
      exp_valid = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [119:0] act, input logic [119:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s]: actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R7 in_ready", 120'(in_ready), 120'(!exp_valid || out_ready));
    check("R5 out_valid", 120'(out_valid), 120'(exp_valid));
    check("R3 systematic bits", 120'(out_frame[87:0]), 120'(exp_frame[87:0]));
    check("R4 parity bits", 120'(out_frame[119:88]), 120'(exp_frame[119:88]));
    if (out_valid === 1'b1)
      check("R1 codeword roots", 120'(roots_zero(out_frame)), 120'(1));
  endtask

  task automatic drive(input logic v, input logic [87:0] p, input logic r);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_payload = p;
    out_ready = r;
  endtask

  function automatic logic [87:0] rnd88();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    // R9: reset state
    repeat (3) drive(1'b1, rnd88(), 1'b0);
    @(negedge clk);
    check("R9 reset in_ready", 120'(in_ready), 120'(1));
    check("R9 reset out_valid", 120'(out_valid), 120'(0));
    check("R9 reset out_frame", out_frame, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    phase = "R4 zero payload";
    drive(1'b1, '0, 1'b1);
    drive(1'b0, rnd88(), 1'b1);
    drive(1'b0, rnd88(), 1'b1);

    phase = "R2 single symbol walk";
    for (int k = 0; k < 22; k++) begin
      logic [87:0] p = '0;
      p[k*4 +: 4] = 4'((k % 15) + 1);
      drive(1'b1, p, 1'b1);
    end

    phase = "R3 all ones";
    drive(1'b1, '1, 1'b1);

    phase = "R7 back to back";
    for (int n = 0; n < 200; n++) drive(1'b1, rnd88(), 1'b1);

    phase = "R6 back-pressure";
    for (int n = 0; n < 400; n++) drive(1'(($urandom() % 4) != 0), rnd88(), 1'(($urandom() % 3) == 0));

    phase = "R8 idle junk";
    drive(1'b1, rnd88(), 1'b1);
    for (int n = 0; n < 12; n++) drive(1'b0, rnd88(), 1'(n > 5));

    phase = "R5 mixed traffic";
    for (int n = 0; n < 300; n++) drive(1'($urandom() % 2), rnd88(), 1'(($urandom() % 4) != 0));
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R5 watchdog: actual run still going, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule